// File: doc/BRIEF.md
# Multilevel Switching Sequence Timer

This block plays out a space-vector modulation result for a four-leg, five-level converter, one switching period at a time. A calculation engine upstream supplies four switching vectors and the dwell fractions of the first three. Each vector holds a signed level code for each of the four legs: three phase legs and the neutral leg. The block counts a fixed switching period derived from the system clock. It applies the four vectors in their given order, each for its share of the period, and drives the level code of every leg on its outputs.

A new set of vectors and fractions is taken only at the period boundary. The outputs therefore never change their sequence part-way through a period. At the start of each period a one-cycle pulse asks the upstream engine for the next set. That set must be stable on the inputs by the last clock of the period. Fractions are turned into clock ticks by a multiply and shift. The last vector takes whatever ticks remain, so rounding never changes the period length. A vector whose share comes to zero ticks is never driven.

Top module: `mst_seq_timer`

## Requirements
- R1: While reset is high and on the first clock after it, `start_o` is 0 and every leg of `lvl_o` is 0. The first period after reset drives level 0 on all legs for its whole length.
- R2: The period is PERIOD = CLK_HZ / SW_HZ clocks. `start_o` is high for exactly one clock per period, and consecutive pulses are exactly PERIOD clocks apart.
- R3: Within a period the vectors appear in index order 0, 1, 2, 3. Each occupies one contiguous run of clocks, and the period starts with the first vector whose run is not empty.
- R4: Fraction j (j = 0..2) is an unsigned FRAC_W+1 bit field at `frac_i[j*(FRAC_W+1) +: FRAC_W+1]`, where 2^FRAC_W means one whole period. Vector j lasts floor(frac_j * PERIOD / 2^FRAC_W) clocks. Vector 3 lasts the rest of the period.
- R5: A vector whose tick count is zero does not appear on `lvl_o` at all in that period.
- R6: `vec_i` and `frac_i` are sampled only on the last clock of a period. Any change at other times has no effect on the period in progress.
- R7: For every leg, the sum of its level over one period equals the sum, over the four vectors, of the vector's tick count times that leg's level in that vector.
- R8: Leg k of vector j is a signed two's complement 3-bit code at `vec_i[(4*j+k)*3 +: 3]`. The legs in order k = 0..3 are phases a, b, c and neutral. Codes below LVL_MIN are driven as LVL_MIN, and codes above LVL_MAX are driven as LVL_MAX (defaults -2 and +2).
- R9: If the running total of the first fractions reaches or exceeds the period, it saturates at the period. The vectors after that point get zero clocks, and a fraction of exactly 2^FRAC_W gives the whole period to its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_i | input | 48 | Four switching vectors, 4 legs of 3-bit signed level each |
| frac_i | input | 3*(FRAC_W+1) | Dwell fractions of vectors 0..2 |
| lvl_o | output | 12 | Current level code of legs a, b, c, neutral (3 bits each) |
| start_o | output | 1 | One-clock pulse on the first clock of each period |

## Verification
The bench builds the block with CLK_HZ = 1,370,000 and SW_HZ = 10,000, which gives a 137-clock period. Because this length is odd, nearly every fraction lands between whole ticks, so the floor rounding and the way vector 3 takes the remainder are checked in every period. The short period lets a few thousand clocks cover the main cases: zero shares, a full-period share, saturating fraction sums, clamped codes, and inputs that change mid-period. Each of these gets its own period. That period is compared tick by tick and by per-leg sum against values computed from the requirements.

// File: rtl/mst_pkg.sv
package mst_pkg;

    // Four legs (three phases plus neutral) and four vectors per period
    localparam int LEGS  = 4;
    localparam int NVEC  = 4;
    localparam int NFRAC = NVEC - 1;
    localparam int LVL_W = 3;
    localparam int VEC_W = LEGS * LVL_W;

    typedef logic signed [LVL_W-1:0] lvl_t;
    typedef lvl_t [LEGS-1:0]         svec_t;
    typedef svec_t [NVEC-1:0]        seq_t;
    typedef logic [1:0]              slot_t;

    // Saturate one leg code into the allowed level window
    function automatic lvl_t lvl_clamp(lvl_t x, int lo, int hi);
        int v;
        v = int'(x);
        if (v < lo)
            return lvl_t'(lo);
        else if (v > hi)
            return lvl_t'(hi);
        else
            return x;
    endfunction

    // True when every leg of a vector lies inside the window
    function automatic logic vec_in_range(svec_t v, int lo, int hi);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < LEGS; k++) begin
            if (int'(v[k]) < lo || int'(v[k]) > hi)
                ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/mst_period_ctr.sv
module mst_period_ctr #(
    parameter int PERIOD = 25000,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             first_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_o <= '0;
        else if (wrap_o)
            cnt_o <= '0;
        else
            cnt_o <= cnt_o + CNT_W'(1);
    end

    assign wrap_o  = (cnt_o == LAST);
    assign first_o = (cnt_o == '0);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= LAST);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_o != LAST) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

endmodule

// File: rtl/mst_dwell_scale.sv
module mst_dwell_scale
    import mst_pkg::*;
#(
    parameter int PERIOD = 25000,
    parameter int FRAC_W = 16,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic [NFRAC*(FRAC_W+1)-1:0] frac_i,
    output logic [NFRAC-1:0][CNT_W-1:0] bnd_o
);

    localparam int FW = FRAC_W + 1;
    localparam int PW = FW + CNT_W;
    localparam int TW = PW - FRAC_W;
    localparam int AW = CNT_W + 2;

    logic [NFRAC-1:0][TW-1:0] tick;

    // Fraction times period, scaled back by a shift
    generate
        for (genvar j = 0; j < NFRAC; j++) begin : g_scale
            logic [PW-1:0] prod;
            assign prod    = PW'(frac_i[j*FW +: FW]) * PW'(PERIOD);
            assign tick[j] = prod[PW-1:FRAC_W];
        end
    endgenerate

    // Running end points, saturating at the period length
    always_comb begin
        logic [AW-1:0] acc;
        acc = '0;
        for (int j = 0; j < NFRAC; j++) begin
            acc = acc + AW'(tick[j]);
            if (acc > AW'(PERIOD))
                acc = AW'(PERIOD);
            bnd_o[j] = acc[CNT_W-1:0];
        end
    end

    // R9
    always_comb begin
        bnd_order_chk: assert (bnd_o[0] <= bnd_o[1] && bnd_o[1] <= bnd_o[2]
                               && bnd_o[2] <= CNT_W'(PERIOD));
    end

endmodule

// File: rtl/mst_level_clamp.sv
module mst_level_clamp
    import mst_pkg::*;
#(
    parameter int LVL_MIN = -2,
    parameter int LVL_MAX = 2
) (
    input  seq_t raw_i,
    output seq_t sat_o
);

    generate
        for (genvar j = 0; j < NVEC; j++) begin : g_vec
            for (genvar k = 0; k < LEGS; k++) begin : g_leg
                assign sat_o[j][k] = lvl_clamp(raw_i[j][k], LVL_MIN, LVL_MAX);
            end
        end
    endgenerate

endmodule

// File: rtl/mst_seq_timer.sv
module mst_seq_timer
    import mst_pkg::*;
#(
    parameter int CLK_HZ  = 250_000_000,
    parameter int SW_HZ   = 10_000,
    parameter int FRAC_W  = 16,
    parameter int LVL_MIN = -2,
    parameter int LVL_MAX = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NVEC*VEC_W-1:0]       vec_i,
    input  logic [NFRAC*(FRAC_W+1)-1:0] frac_i,
    output logic [VEC_W-1:0]            lvl_o,
    output logic                        start_o
);

    localparam int PERIOD = CLK_HZ / SW_HZ;
    localparam int CNT_W  = $clog2(PERIOD + 1);

    logic [CNT_W-1:0]            cnt;
    logic                        wrap;
    logic                        first;
    seq_t                        raw_seq;
    seq_t                        sat_seq;
    logic [NFRAC-1:0][CNT_W-1:0] bnd_new;

    seq_t                        seq_q;
    logic [NFRAC-1:0][CNT_W-1:0] bnd_q;
    slot_t                       slot;
    svec_t                       lvl_q;
    logic                        start_q;

    assign raw_seq = vec_i;

    mst_period_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) ctr_i (
        .clk     (clk),
        .rst     (rst),
        .cnt_o   (cnt),
        .wrap_o  (wrap),
        .first_o (first)
    );

    mst_dwell_scale #(.PERIOD(PERIOD), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) scale_i (
        .frac_i (frac_i),
        .bnd_o  (bnd_new)
    );

    mst_level_clamp #(.LVL_MIN(LVL_MIN), .LVL_MAX(LVL_MAX)) clamp_i (
        .raw_i (raw_seq),
        .sat_o (sat_seq)
    );

    // Take a new set only on the last clock of a period
    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
            bnd_q <= '0;
        end else if (wrap) begin
            seq_q <= sat_seq;
            bnd_q <= bnd_new;
        end
    end

    // Which vector owns the current tick
    always_comb begin
        if (cnt < bnd_q[0])
            slot = 2'd0;
        else if (cnt < bnd_q[1])
            slot = 2'd1;
        else if (cnt < bnd_q[2])
            slot = 2'd2;
        else
            slot = 2'd3;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= '0;
            start_q <= 1'b0;
        end else begin
            lvl_q   <= seq_q[slot];
            start_q <= first;
        end
    end

    assign lvl_o   = lvl_q;
    assign start_o = start_q;

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(seq_q) && $stable(bnd_q)));

    // R3
    slot_order_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> (slot >= $past(slot)));

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    // R8
    lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
        vec_in_range(lvl_q, LVL_MIN, LVL_MAX));

endmodule

// File: tb/mst_seq_timer_tb_top.sv
module mst_seq_timer_tb_top;
    import mst_pkg::*;

    localparam int CLK_HZ = 1_370_000;
    localparam int SW_HZ  = 10_000;
    localparam int FRAC_W = 16;
    localparam int FW     = FRAC_W + 1;
    localparam int P      = CLK_HZ / SW_HZ;
    localparam int NITEM  = 9;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NVEC*VEC_W-1:0] vec_i = '0;
    logic [NFRAC*FW-1:0]   frac_i = '0;
    logic [VEC_W-1:0]      lvl_o;
    logic                  start_o;

    always #2 clk = ~clk;

    mst_seq_timer #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ), .FRAC_W(FRAC_W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .vec_i   (vec_i),
        .frac_i  (frac_i),
        .lvl_o   (lvl_o),
        .start_o (start_o)
    );

    typedef struct {
        int    lvl[4][4];
        int    b[3];
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   stage_v[4][4];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clampi(int x);
        if (x < -2) return -2;
        if (x > 2) return 2;
        return x;
    endfunction

    function automatic int sx(logic [2:0] b);
        return int'($signed(b));
    endfunction

    task automatic set_vec(int j, int a, int bb, int c, int n);
        stage_v[j][0] = a;
        stage_v[j][1] = bb;
        stage_v[j][2] = c;
        stage_v[j][3] = n;
    endtask

    // Driver: on a period start, drive the next set and push its expectation
    task automatic apply(int f0, int f1, int f2, string tag, bit junk);
        exp_t    e;
        int      f[3];
        longint  acc;
        f[0] = f0; f[1] = f1; f[2] = f2;
        do @(negedge clk); while (!start_o);
        if (junk) begin
            vec_i  = {$urandom, $urandom};
            frac_i = {$urandom, $urandom};
            repeat (P / 2) @(negedge clk);
        end
        for (int j = 0; j < 4; j++)
            for (int k = 0; k < 4; k++) begin
                vec_i[(j*4+k)*3 +: 3] = 3'(stage_v[j][k]);
                e.lvl[j][k] = clampi(sx(3'(stage_v[j][k])));
            end
        acc = 0;
        for (int j = 0; j < 3; j++) begin
            frac_i[j*FW +: FW] = FW'(f[j]);
            acc = acc + ((longint'(f[j]) * P) >>> FRAC_W);
            if (acc > P) acc = P;
            e.b[j] = int'(acc);
        end
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic driver();
        // R3: ordered sequence, unit steps between neighbours
        set_vec(0, 2, -1, 0, 1); set_vec(1, 2, -1, 0, 2);
        set_vec(2, 2, 0, 0, 2);  set_vec(3, 2, 0, 1, 2);
        apply(17695, 17039, 19661, "R3", 1'b0);
        // R4: thirds round down, last vector takes the remainder
        set_vec(0, 1, 0, 0, 0); set_vec(1, 1, 1, 0, 0);
        set_vec(2, 1, 1, 1, 0); set_vec(3, 1, 1, 1, 1);
        apply(21845, 21845, 21845, "R4", 1'b0);
        // R5: vectors 0 and 2 have no share
        set_vec(0, -2, -2, -2, -2); set_vec(1, -1, -1, -1, -1);
        set_vec(2, 0, 0, 0, 0);     set_vec(3, 1, 1, 1, 1);
        apply(0, 30000, 0, "R5", 1'b0);
        // R8: codes outside the window are clamped
        set_vec(0, 3, -4, -3, 2); set_vec(1, -4, 3, 1, -1);
        set_vec(2, 3, 3, -3, 0);  set_vec(3, -3, 2, -2, 3);
        apply(20000, 20000, 20000, "R8", 1'b0);
        // R9: sum of the first two passes the period
        set_vec(0, 0, 1, 2, -1); set_vec(1, 1, 2, -1, 0);
        set_vec(2, 2, -2, 0, 1); set_vec(3, -1, 0, 1, 2);
        apply(45875, 39322, 30000, "R9", 1'b0);
        // R9: one full period for vector 0
        set_vec(0, -2, 2, -1, 1); set_vec(1, 1, 1, 1, 1);
        set_vec(2, 2, 2, 2, 2);   set_vec(3, 0, 0, 0, 0);
        apply(65536, 0, 0, "R9", 1'b0);
        // R6: garbage on the inputs during the period before
        set_vec(0, 0, 0, 0, 0); set_vec(1, 0, 0, 0, 1);
        set_vec(2, 0, 0, 1, 1); set_vec(3, 0, 1, 1, 1);
        apply(10000, 15000, 25000, "R6", 1'b1);
        // R7: irregular shares
        for (int r = 0; r < 2; r++) begin
            for (int j = 0; j < 4; j++)
                set_vec(j, int'($urandom_range(0, 4)) - 2, int'($urandom_range(0, 4)) - 2,
                        int'($urandom_range(0, 4)) - 2, int'($urandom_range(0, 4)) - 2);
            apply(int'($urandom_range(0, 21000)), int'($urandom_range(0, 21000)),
                  int'($urandom_range(0, 21000)), "R7", 1'b0);
        end
    endtask

    // Monitor: pop one expectation per period and compare tick by tick
    task automatic monitor(int nper);
        do @(negedge clk); while (!start_o);
        for (int p = 0; p < nper; p++) begin
            exp_t e;
            int   sum[4];
            int   bad_i, bad_a, bad_e, slot, seg, early;
            int   len[4];
            if (q.size() == 0) begin
                chk(1'b0, "R2", "expectation queue empty", p, 0);
                return;
            end
            e = q.pop_front();
            bad_i = -1; bad_a = 0; bad_e = 0; early = 0;
            for (int k = 0; k < 4; k++) sum[k] = 0;
            for (int i = 0; i < P; i++) begin
                if (i > 0) @(negedge clk);
                if (i > 0 && start_o) early = 1;
                slot = (i < e.b[0]) ? 0 : (i < e.b[1]) ? 1 : (i < e.b[2]) ? 2 : 3;
                for (int k = 0; k < 4; k++) begin
                    int a;
                    a = sx(lvl_o[k*3 +: 3]);
                    sum[k] += a;
                    if (a != e.lvl[slot][k] && bad_i < 0) begin
                        bad_i = i; bad_a = a; bad_e = e.lvl[slot][k];
                    end
                end
            end
            chk(bad_i < 0, e.tag, $sformatf("period %0d tick %0d level", p, bad_i), bad_a, bad_e);
            len[0] = e.b[0]; len[1] = e.b[1] - e.b[0];
            len[2] = e.b[2] - e.b[1]; len[3] = P - e.b[2];
            for (int k = 0; k < 4; k++) begin
                int w;
                w = 0;
                for (seg = 0; seg < 4; seg++) w += len[seg] * e.lvl[seg][k];
                chk(sum[k] == w, "R7", $sformatf("period %0d leg %0d sum", p, k), sum[k], w);
            end
            @(negedge clk);
            chk(start_o == 1'b1 && early == 0, "R2", "start pulse spacing",
                int'(start_o) - early, 1);
        end
    endtask

    initial begin
        exp_t z;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(start_o == 1'b0, "R1", "start during reset", int'(start_o), 0);
        chk(lvl_o == '0, "R1", "levels during reset", int'(lvl_o), 0);
        for (int j = 0; j < 4; j++)
            for (int k = 0; k < 4; k++) z.lvl[j][k] = 0;
        z.b[0] = 0; z.b[1] = 0; z.b[2] = 0;
        z.tag = "R1";
        q.push_back(z);
        rst = 1'b0;
        @(negedge clk);
        chk(start_o == 1'b1, "R1", "first pulse after reset", int'(start_o), 1);
        fork
            driver();
            monitor(NITEM + 1);
        join
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 20000, (NITEM + 2) * P);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule